// File: doc/BRIEF.md
# Host Controller Interrupt Register Block

This block holds the interrupt bookkeeping of a USB host controller. Single-cycle event pulses from the controller's internal engines set latched status bits. Software reads the latched bits through a 32-bit word-addressed register port and acknowledges them by writing ones.

Two write-one registers act on one shared enable mask. The first sets mask bits and the second clears them, and a read of either returns the mask. Bit 31 of the mask is a master enable that is not an event source. A single level interrupt output is raised when the master enable is set and at least one latched status bit has its mask bit set.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset the status register and the mask are zero and `irq_o` is low.
- R2: A pulse on `evt_i[k]` (k = 0..6) sets status bit k, and a pulse on `evt_i[7]` sets status bit 30 (ownership change). This happens on the next clock edge whatever the mask holds.
- R3: A write to word offset 3 (status) clears every implemented status bit written as one. Bits written as zero keep their value.
- R4: When an event pulse and a write-one-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to word offset 4 (enable) sets each mask bit written as one. Writable mask bits are 0..6, 30 and 31, and bits written as zero are unchanged.
- R6: A write to word offset 5 (disable) clears each writable mask bit written as one. Bits written as zero are unchanged.
- R7: Reads of offset 4 and offset 5 both return the current mask, including master bit 31.
- R8: `irq_o` is high exactly when mask bit 31 is set and the AND of status and mask over bits 0..30 is nonzero.
- R9: Bits 7..29 of status and mask read as zero and ignore writes. Bit 31 of status is always zero. Reads of any offset other than 3, 4 and 5 return zero, and writes to them change nothing.
- R10: A read of offset 3 returns the latched status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses; bits 0..6 map to status 0..6, bit 7 to status 30 |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when no read |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each event source is pulsed in turn and read back, which shows that the bit placement, including the jump to bit 30, is right. Every source is then crossed with every single-bit mask under master on and off, so the interrupt output is tried under all matched and unmatched pairs. This separates a wrong AND from a missing master gate. Write-one-clear is tried with single bits, with zero writes and with an event landing in the clear cycle. All-ones writes and reads of unused offsets show that reserved bits and offsets stay inert.

// File: rtl/hcint_pkg.sv
package hcint_pkg;
    localparam int DATA_W     = 32;
    localparam int NSRC       = 8;
    localparam int LOW_SRC    = 7;
    localparam int OWN_BIT    = 30;
    localparam int MASTER_BIT = 31;

    localparam logic [DATA_W-1:0] SRC_BITS  = 32'h4000_007F;
    localparam logic [DATA_W-1:0] MASK_BITS = 32'hC000_007F;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_DIS
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] place_events(input logic [NSRC-1:0] e);
        logic [DATA_W-1:0] r;
        r = '0;
        r[LOW_SRC-1:0] = e[LOW_SRC-1:0];
        r[OWN_BIT]     = e[NSRC-1];
        return r;
    endfunction
endpackage

// File: rtl/hcint_status.sv
module hcint_status
    import hcint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] stat_o
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < DATA_W; b++) begin
            if (SRC_BITS[b]) begin
                if (set_bits[b])
                    st_d.stat[b] = 1'b1;
                else if (clr_bits[b])
                    st_d.stat[b] = 1'b0;
            end else begin
                st_d.stat[b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_bits & SRC_BITS)) |=> ((st_q.stat & $past(set_bits & SRC_BITS)) == $past(set_bits & SRC_BITS)));

    // R3
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(st_q.stat) & ~st_q.stat & ~$past(clr_bits)) == '0));
endmodule

// File: rtl/hcint_mask.sv
module hcint_mask
    import hcint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] mask_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        mk_d.mask = (mk_q.mask | (set_bits & MASK_BITS)) & ~(clr_bits & MASK_BITS);
        mk_d.mask = mk_d.mask & MASK_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mk_q <= '0;
        else
            mk_q <= mk_d;
    end

    assign mask_o = mk_q.mask;

    // R5
    en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_bits) && !(|clr_bits)) |=> ((mk_q.mask & $past(set_bits & MASK_BITS)) == $past(set_bits & MASK_BITS)));

    // R6
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((mk_q.mask & $past(clr_bits)) == '0));
endmodule

// File: rtl/hcint_regport.sv
module hcint_regport
    import hcint_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int STAT_OFS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] stat_clr,
    output logic [DATA_W-1:0] mask_set,
    output logic [DATA_W-1:0] mask_clr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(STAT_OFS + 1);
    localparam logic [ADDR_W-1:0] OFS_DIS  = ADDR_W'(STAT_OFS + 2);

    reg_sel_e which;

    always_comb begin
        which = SEL_NONE;
        if (sel) begin
            if (addr == OFS_STAT)     which = SEL_STAT;
            else if (addr == OFS_EN)  which = SEL_EN;
            else if (addr == OFS_DIS) which = SEL_DIS;
        end
    end

    always_comb begin
        stat_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        rdata    = '0;
        if (wr) begin
            case (which)
                SEL_STAT: stat_clr = wdata & SRC_BITS;
                SEL_EN:   mask_set = wdata & MASK_BITS;
                SEL_DIS:  mask_clr = wdata & MASK_BITS;
                default:  ;
            endcase
        end else begin
            case (which)
                SEL_STAT: rdata = stat & SRC_BITS;
                SEL_EN,
                SEL_DIS:  rdata = mask & MASK_BITS;
                default:  rdata = '0;
            endcase
        end
    end

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|stat_clr, |mask_set, |mask_clr}));

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == '0));
endmodule

// File: rtl/hcint_irq_gen.sv
module hcint_irq_gen
    import hcint_pkg::*;
(
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic [DATA_W-2:0] hits;

    always_comb begin
        hits = stat[DATA_W-2:0] & mask[DATA_W-2:0];
        irq  = mask[MASTER_BIT] & (|hits);
    end
endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
    import hcint_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int STAT_OFS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic [DATA_W-1:0] evt_bits;
    logic [DATA_W-1:0] stat_w, mask_w;
    logic [DATA_W-1:0] stat_clr_w, mask_set_w, mask_clr_w;

    assign evt_bits = place_events(evt_i);

    hcint_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (evt_bits),
        .clr_bits (stat_clr_w),
        .stat_o   (stat_w)
    );

    hcint_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (mask_set_w),
        .clr_bits (mask_clr_w),
        .mask_o   (mask_w)
    );

    hcint_regport #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (reg_sel),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .stat     (stat_w),
        .mask     (mask_w),
        .stat_clr (stat_clr_w),
        .mask_set (mask_set_w),
        .mask_clr (mask_clr_w),
        .rdata    (reg_rdata)
    );

    hcint_irq_gen u_irq (
        .stat (stat_w),
        .mask (mask_w),
        .irq  (irq_o)
    );

    // R8
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_w[MASTER_BIT] |-> !irq_o);

    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_bits & stat_clr_w)) |=> ((stat_w & $past(evt_bits & stat_clr_w)) == $past(evt_bits & stat_clr_w)));
endmodule

// File: tb/hc_irq_regs_test.sv
module hc_irq_regs_test;
    localparam logic [31:0] SRCM = 32'h4000_007F;
    localparam logic [31:0] MSKM = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_stat = '0;
    logic [31:0] exp_mask = '0;

    always #2 clk = ~clk;

    hc_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] ebits(input logic [7:0] e);
        logic [31:0] r;
        r = '0;
        r[6:0] = e[6:0];
        r[30] = e[7];
        return r;
    endfunction

    function automatic logic exp_irq();
        return exp_mask[31] && ((exp_stat[30:0] & exp_mask[30:0]) != 0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic wr_evt(input logic [3:0] a, input logic [31:0] d, input logic [7:0] e);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_i = e;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; evt_i = '0;
        if (a == 4'd3) exp_stat = (exp_stat & ~(d & SRCM)) | ebits(e);
        else begin
            exp_stat = exp_stat | ebits(e);
            if (a == 4'd4) exp_mask = exp_mask | (d & MSKM);
            if (a == 4'd5) exp_mask = exp_mask & ~(d & MSKM);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_evt(a, d, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
        exp_stat = exp_stat | ebits(e);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd3, d); chk("R1 status", d, 32'h0);
        rd(4'd4, d); chk("R1 mask", d, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 R10: each source, with mask all zero
        for (int s = 0; s < 8; s++) begin
            pulse(8'(1 << s));
            rd(4'd3, d); chk("R2 R10 event placement", d, exp_stat);
            chk("R8 no irq with empty mask", {31'b0, irq_o}, 32'h0);
            wr(4'd3, ebits(8'(1 << s)));
            rd(4'd3, d); chk("R3 clear", d, 32'h0);
        end

        // R8 sweep: source x single mask bit x master
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 8; m++) begin
                for (int ms = 0; ms < 2; ms++) begin
                    wr(4'd5, 32'hFFFF_FFFF);
                    wr(4'd4, ebits(8'(1 << m)) | (ms != 0 ? 32'h8000_0000 : 32'h0));
                    pulse(8'(1 << s));
                    #1 chk("R8 irq sweep", {31'b0, irq_o}, {31'b0, exp_irq()});
                    wr(4'd3, 32'hFFFF_FFFF);
                    #1 chk("R8 irq after clear", {31'b0, irq_o}, 32'h0);
                end
            end
        end

        // R5 R6 R7 mask reads
        wr(4'd5, 32'hFFFF_FFFF);
        wr(4'd4, 32'h8000_0005);
        rd(4'd4, d); chk("R5 R7 enable read", d, 32'h8000_0005);
        wr(4'd4, 32'h0000_0000);
        rd(4'd5, d); chk("R5 zero write no effect / R7 disable read", d, 32'h8000_0005);
        wr(4'd5, 32'h0000_0004);
        rd(4'd5, d); chk("R6 disable clears", d, 32'h8000_0001);
        rd(4'd4, d); chk("R7 enable read", d, exp_mask);

        // R9 reserved bits
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, d); chk("R9 mask reserved", d, 32'hC000_007F);
        pulse(8'hFF);
        rd(4'd3, d); chk("R9 R10 status reserved", d, 32'h4000_007F);
        chk("R8 irq all", {31'b0, irq_o}, 32'h1);
        wr(4'd3, 32'h0000_0000);
        rd(4'd3, d); chk("R3 zero write", d, 32'h4000_007F);
        for (int a = 0; a < 16; a++) begin
            if (a < 3 || a > 5) begin
                wr(4'(a), 32'hFFFF_FFFF);
                rd(4'(a), d); chk("R9 unused offset read", d, 32'h0);
            end
        end
        rd(4'd3, d); chk("R9 unused writes no effect status", d, 32'h4000_007F);
        rd(4'd4, d); chk("R9 unused writes no effect mask", d, 32'hC000_007F);

        // R4 collision
        wr_evt(4'd3, 32'h4000_0002, 8'h80);
        rd(4'd3, d); chk("R4 event wins", d, 32'h0000_007D | 32'h4000_0000);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R3 full clear", d, 32'h0);
        chk("R8 irq low", {31'b0, irq_o}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule